// File: doc/BRIEF.md
# Escaped Frame Receiver with Running CRC-8

This block sits behind a byte transport and turns an escaped byte stream into register writes and memory data strobes. A reserved escape byte (0xA5) introduces two-byte control pairs that open and close a frame. The same escape byte, doubled, carries a literal 0xA5 inside the payload. The first unescaped payload byte of each frame is a packed command. It names the target board or a broadcast, picks register or memory, and carries a write-enable bit and a register address.

A register frame delivers one data byte, which leaves the block as a single-cycle write pulse together with its address. A memory frame forwards every later payload byte as a strobe plus data, with no further decoding. Every payload byte inside a frame, command bytes included, is folded into a running CRC-8. The CRC carries across frames and is zeroed only by a synchronous clear, so software can read the value back and compare it with the CRC of what it sent. The block is always ready to take a byte. Its board number comes from a static input.

Top module: `esc_frame_rx`

## Requirements
- R1: Bytes that arrive while no frame is open are discarded. This includes a doubled 0xA5. They cause no strobe and leave the CRC unchanged. The pair 0xA5 0x02 opens a frame and the pair 0xA5 0x03 closes it.
- R2: Inside a frame, the pair 0xA5 0xA5 is one payload byte of value 0xA5. It is decoded, forwarded and checksummed exactly like any other payload byte.
- R3: The first payload byte is a command. Bit 7 is write enable, bits 6..3 are the board field, bit 2 selects memory (1) or register (0), and bits 1..0 are the register address. For an enabled register command aimed at this board, the next payload byte produces `reg_we` high for exactly one cycle, with `reg_addr` and `reg_data` valid in that cycle. The pulse appears in the cycle after the data byte is accepted.
- R4: A board field equal to `board_id` or equal to 0xF (broadcast) addresses this board. Any other field makes the rest of the frame be consumed with no strobes.
- R5: A command with bit 7 clear produces no strobe for the rest of its frame.
- R6: A register frame writes once. Payload bytes after its data byte produce no strobe, but they still enter the CRC.
- R7: After an enabled memory command aimed at this board, every following payload byte up to the end of the frame produces a one-cycle `mem_we` pulse carrying that byte on `mem_data`. `reg_we` and `mem_we` are never high together.
- R8: `crc_value` is the CRC-8 with polynomial 0x107, taken MSB first with zero start and no final inversion. It covers all payload bytes accepted inside frames since the last clear, across frame boundaries. It is updated in the cycle after each such byte and holds otherwise.
- R9: `crc_clear` zeroes the CRC on the next edge. If a payload byte is accepted in the same cycle, the result is the CRC of that byte alone, taken from zero.
- R10: An escape followed by a byte other than 0x02, 0x03 or 0xA5 aborts the open frame, and later bytes are discarded until the next start pair. A start pair inside an open frame restarts parsing with a new command byte.
- R11: After reset, `reg_we` and `mem_we` are low, `crc_value` is zero, no frame is open, and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| board_id | input | 4 | Static number of this board |
| in_valid | input | 1 | Input byte present |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Byte accepted when high (always high) |
| crc_clear | input | 1 | Synchronous CRC clear |
| crc_value | output | 8 | Running CRC-8 |
| reg_we | output | 1 | Register write pulse |
| reg_addr | output | 2 | Register address |
| reg_data | output | 8 | Register data |
| mem_we | output | 1 | Memory data strobe |
| mem_data | output | 8 | Memory data byte |

## Verification
The block has no parameters, so the bench builds its single configuration and instead sweeps the static `board_id` input over several values. For each board number it drives every board field, every register address and both write-enable settings. This covers the whole addressing space, including the broadcast code and board number 0xF. One memory frame carries all 256 byte values, so the doubled-escape path is exercised in place. The expected CRC is computed bit-serially in the bench and compared after the sweep, after aborted and restarted frames, and around clears.

// File: rtl/esc_frame_rx.sv
module esc_frame_rx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] board_id,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic       in_ready,
  input  logic       crc_clear,
  output logic [7:0] crc_value,
  output logic       reg_we,
  output logic [1:0] reg_addr,
  output logic [7:0] reg_data,
  output logic       mem_we,
  output logic [7:0] mem_data
);
  localparam logic [7:0] ESC   = 8'hA5;
  localparam logic [7:0] OPEN  = 8'h02;
  localparam logic [3:0] BCAST = 4'hF;
  localparam logic [7:0] POLY  = 8'h07;

  typedef enum logic [2:0] {S_OUT, S_CMD, S_REG, S_MEM, S_SKIP} st_t;

  st_t  st;
  logic esc;

  function automatic logic [7:0] crc_step(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] x;
    x = c ^ d;
    for (int i = 0; i < 8; i++) x = x[7] ? ((x << 1) ^ POLY) : (x << 1);
    return x;
  endfunction

  assign in_ready = 1'b1;

  wire is_esc = (in_data == ESC);
  wire ctl    = in_valid && esc && !is_esc;
  wire lit    = in_valid && (esc == is_esc) && (st != S_OUT);
  wire hit    = (in_data[6:3] == board_id) || (in_data[6:3] == BCAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_OUT;
      esc       <= 1'b0;
      crc_value <= '0;
      reg_we    <= 1'b0;
      reg_addr  <= '0;
      reg_data  <= '0;
      mem_we    <= 1'b0;
      mem_data  <= '0;
    end else begin
      reg_we <= 1'b0;
      mem_we <= 1'b0;
      if (in_valid) esc <= esc ? 1'b0 : is_esc;
      if (ctl) st <= (in_data == OPEN) ? S_CMD : S_OUT;
      else if (lit) begin
        case (st)
          S_CMD: begin
            if (!hit || !in_data[7]) st <= S_SKIP;
            else if (in_data[2])     st <= S_MEM;
            else begin
              st       <= S_REG;
              reg_addr <= in_data[1:0];
            end
          end
          S_REG: begin
            reg_we   <= 1'b1;
            reg_data <= in_data;
            st       <= S_SKIP;
          end
          S_MEM: begin
            mem_we   <= 1'b1;
            mem_data <= in_data;
          end
          default: ;
        endcase
      end
      if (lit)            crc_value <= crc_step(crc_clear ? 8'h00 : crc_value, in_data);
      else if (crc_clear) crc_value <= '0;
    end
  end

  p_strobe_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && mem_we));
  p_reg_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);
  p_strobe_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we || mem_we) |-> $past(in_valid));
  p_out_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_OUT && in_valid) |=> (!reg_we && !mem_we));
  p_crc_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !crc_clear) |=> $stable(crc_value));
  p_crc_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (crc_clear && !in_valid) |=> (crc_value == 8'h00));
endmodule

// File: tb/esc_frame_rx_tb_top.sv
module esc_frame_rx_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] board_id = 4'd3;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_ready;
  logic       crc_clear = 1'b0;
  logic [7:0] crc_value;
  logic       reg_we;
  logic [1:0] reg_addr;
  logic [7:0] reg_data;
  logic       mem_we;
  logic [7:0] mem_data;

  int checks = 0;
  int errors = 0;
  int reg_cnt = 0;
  int mem_cnt = 0;
  logic [1:0] last_addr;
  logic [7:0] last_data;
  logic [7:0] mem_log [0:511];
  logic [7:0] bcrc = 8'h00;

  always #5 clk = ~clk;

  esc_frame_rx dut_i (
    .clk(clk), .rst_n(rst_n), .board_id(board_id), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .crc_clear(crc_clear),
    .crc_value(crc_value), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_data(reg_data), .mem_we(mem_we), .mem_data(mem_data)
  );

  always @(negedge clk) if (rst_n) begin
    if (reg_we) begin
      reg_cnt++;
      last_addr = reg_addr;
      last_data = reg_data;
    end
    if (mem_we) begin
      if (mem_cnt < 512) mem_log[mem_cnt] = mem_data;
      mem_cnt++;
    end
  end

  function automatic logic [7:0] crc_ref(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    logic fb;
    r = c;
    for (int b = 7; b >= 0; b--) begin
      fb = r[7] ^ d[b];
      r = {r[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
    end
    return r;
  endfunction

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tx(input logic [7:0] b, input logic clr = 1'b0);
    in_valid = 1'b1;
    in_data = b;
    crc_clear = clr;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    crc_clear = 1'b0;
  endtask

  task automatic pay(input logic [7:0] b);
    if (b == 8'hA5) begin
      tx(8'hA5);
      tx(8'hA5);
    end else tx(b);
    bcrc = crc_ref(bcrc, b);
  endtask

  task automatic sof();
    tx(8'hA5);
    tx(8'h02);
  endtask

  task automatic eof();
    tx(8'hA5);
    tx(8'h03);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int r0, m0;
    logic [7:0] cmd, d, c1;
    logic hit;
    int ids [3];
    ids = '{0, 5, 15};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(1);
    // R11 reset state
    chk(!reg_we && !mem_we, "R11 strobes after reset", {reg_we, mem_we}, 0);
    chk(crc_value == 8'h00, "R11 crc after reset", crc_value, 0);
    chk(in_ready == 1'b1, "R11 in_ready", in_ready, 1);

    // R3 known broadcast write F8 E5
    r0 = reg_cnt;
    sof(); pay(8'hF8); pay(8'hE5); eof(); idle(2);
    chk(reg_cnt == r0 + 1, "R3 broadcast write count", reg_cnt - r0, 1);
    chk(last_addr == 2'd0 && last_data == 8'hE5, "R3 broadcast write value", {last_addr, last_data}, 16'h00E5);
    chk(crc_value == bcrc, "R8 crc after first frame", crc_value, bcrc);

    // R4 R5 R3 sweep of board id, board field, address, enable
    foreach (ids[k]) begin
      board_id = 4'(ids[k]);
      for (int f = 0; f < 16; f++)
        for (int a = 0; a < 4; a++)
          for (int w = 0; w < 2; w++) begin
            cmd = {1'(w), 4'(f), 1'b0, 2'(a)};
            d = 8'(f * 16 + a * 5 + w * 3 + k * 7 + 8'h60);
            hit = (w == 1) && (f == ids[k] || f == 15);
            r0 = reg_cnt;
            sof(); pay(cmd); pay(d); eof(); idle(2);
            if (hit) begin
              chk(reg_cnt == r0 + 1, "R4 addressed write count", reg_cnt - r0, 1);
              chk(last_addr == 2'(a) && last_data == d, "R3 addressed write value",
                  {last_addr, last_data}, {2'(a), d});
            end else
              chk(reg_cnt == r0, "R5 R4 no write when disabled or not addressed", reg_cnt - r0, 0);
          end
    end
    chk(crc_value == bcrc, "R8 crc across sweep frames", crc_value, bcrc);

    // R6 extra bytes after register data
    board_id = 4'd5;
    r0 = reg_cnt;
    sof(); pay(8'hF9); pay(8'h11); pay(8'h22); pay(8'h33); eof(); idle(2);
    chk(reg_cnt == r0 + 1 && last_data == 8'h11, "R6 single write per frame", reg_cnt - r0, 1);
    chk(crc_value == bcrc, "R6 extra bytes checksummed", crc_value, bcrc);

    // R7 R2 memory frame with every byte value
    m0 = mem_cnt;
    sof(); pay(8'hAC);
    for (int i = 0; i < 256; i++) pay(8'(i));
    eof(); idle(2);
    chk(mem_cnt == m0 + 256, "R7 memory strobe count", mem_cnt - m0, 256);
    for (int i = 0; i < 256; i++)
      chk(mem_log[m0 + i] == 8'(i), "R7 R2 memory byte value", mem_log[m0 + i], i);
    chk(crc_value == bcrc, "R8 R2 crc after memory frame", crc_value, bcrc);

    // R4 memory frame aimed at another board
    m0 = mem_cnt;
    sof(); pay(8'h9C);
    for (int i = 0; i < 10; i++) pay(8'(i + 40));
    eof(); idle(2);
    chk(mem_cnt == m0, "R4 foreign memory frame silent", mem_cnt - m0, 0);

    // R1 bytes outside any frame
    r0 = reg_cnt; m0 = mem_cnt; c1 = crc_value;
    tx(8'h11); tx(8'hF8); tx(8'hE5); tx(8'hA5); tx(8'hA5); tx(8'hAC); tx(8'h77); idle(2);
    chk(reg_cnt == r0 && mem_cnt == m0, "R1 outside bytes no strobe", reg_cnt - r0, 0);
    chk(crc_value == c1, "R1 outside bytes keep crc", crc_value, c1);

    // R9 clear alone, then clear with a payload byte
    tx(8'h00, 1'b1);
    in_valid = 1'b0; crc_clear = 1'b1; @(posedge clk); @(negedge clk); crc_clear = 1'b0;
    chk(crc_value == 8'h00, "R9 clear to zero", crc_value, 0);
    bcrc = 8'h00;
    sof(); pay(8'h12); pay(8'h34);
    in_valid = 1'b1; in_data = 8'h56; crc_clear = 1'b1;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0; crc_clear = 1'b0;
    eof(); idle(1);
    bcrc = crc_ref(8'h00, 8'h56);
    chk(crc_value == bcrc, "R9 clear with byte", crc_value, bcrc);

    // R10 bad escape aborts
    r0 = reg_cnt;
    sof(); pay(8'hF8); tx(8'hA5); tx(8'h07); tx(8'hE5); tx(8'h44); eof(); idle(2);
    chk(reg_cnt == r0, "R10 abort suppresses write", reg_cnt - r0, 0);
    chk(crc_value == bcrc, "R10 crc after abort", crc_value, bcrc);

    // R10 restart on start pair
    r0 = reg_cnt;
    sof(); pay(8'hF8); sof(); pay(8'hF9); pay(8'h3C); eof(); idle(2);
    chk(reg_cnt == r0 + 1, "R10 restart write count", reg_cnt - r0, 1);
    chk(last_addr == 2'd1 && last_data == 8'h3C, "R10 restart write value", {last_addr, last_data}, 16'h013C);
    chk(crc_value == bcrc, "R10 crc after restart", crc_value, bcrc);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule